// File: doc/BRIEF.md
# Program Suspend and Resume Command Controller

This block is the command front end of a flash write engine. It decodes command writes from the host, runs a word program or a block erase as an abstract progress counter, and keeps an eight-bit status register. While a program is running, the host can ask for it to pause. The pause takes effect only at fixed checkpoints in the progress count. The host may then read the array, the status, the identifier or the query table, and later continue the program from the point where it stopped.

A suspended erase lets a program run into any block other than the one being erased. That program can itself be suspended, which gives two levels of suspension. Resume always continues the innermost suspended operation first. Suspend and resume are decoded whatever block address is on the bus. Raising the chip enable puts the block in standby: commands are ignored, but the suspension state is kept. Program and erase timing is set by parameters, and array contents and electrical behaviour are outside this block.

Command codes (byte on `cmd_data`): 0xFF read array, 0x70 read status, 0x90 read identifier, 0x98 read query, 0x40 program setup, 0x20 erase setup, 0xD0 confirm/resume, 0xB0 suspend, 0x50 clear status. Status layout: bit 7 ready, bit 6 erase suspended, bit 4 command-sequence error, bit 2 program suspended, other bits zero. Read mode codes on `rd_mode`: 0 array, 1 status, 2 identifier, 3 query. A write is accepted on a rising clock when `wr_en` is 1 and `ce_n` is 0.

Top module: `psr_ctrl`

## Requirements
- R1: Synchronous active-low reset, also when applied during a suspension, drops any operation. Afterwards status reads 0x80, `rd_mode` is 0 and no operation is pending.
- R2: Writing 0x40 and then any byte starts a program. Status bit 7 is 0 from the edge after the second write until PROG_STEPS progress cycles have passed, and `rd_mode` becomes 1.
- R3: 0xB0 while a program runs is accepted at any block address. Status bits 7 and 2 both become 1 only when the progress count reaches the end of a checkpoint interval (count mod PROG_CKPT equals PROG_CKPT-1, last step excluded). No progress is made while suspended.
- R4: 0xFF, 0x70, 0x90 and 0x98 select read modes 0, 1, 2 and 3. A suspend command and a program or erase start select mode 1.
- R5: While a program is suspended, only 0xFF, 0x70, 0x90, 0x98 and 0xD0 take effect. Any other code is ignored and sets status bit 4.
- R6: 0xD0 at any block address while a program is suspended clears status bits 7 and 2 on the next edge. The program then continues from its stopped count.
- R7: 0xB0 with no operation running is ignored, and status stays 0x80 with no error.
- R8: 0x20 followed by 0xD0 starts an erase, and any other second byte sets bit 4 instead. 0xB0 during an erase sets bits 7 and 6 at an erase checkpoint. While the erase is suspended, the read codes, 0x40, 0xD0 and 0x50 are accepted, and other codes set bit 4.
- R9: A program started during an erase suspend can be suspended (status 0xC4). Resume continues that program, and when it ends the status returns to 0xC0. A further 0xD0 resumes the erase.
- R10: While `ce_n` is 1, writes are ignored and a suspended program stays suspended.
- R11: 0x50 clears status bit 4 when no operation is running or when an erase is suspended.
- R12: A suspend still pending when the program reaches its last step is dropped. The program completes and status returns to 0x80.
- R13: While an operation runs unsuspended, codes other than 0xB0 and 0x70 are ignored without an error.
- R14: 0x40 during an erase suspend with the block address of the suspended erase is refused and sets bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable; high means standby |
| wr_en | input | 1 | Command write strobe |
| blk_addr | input | BLK_W | Block address of the write |
| cmd_data | input | 8 | Command or data byte |
| status | output | 8 | Status register |
| rd_mode | output | 2 | Selected read mode |

## Verification
The risky coincidence is a suspend request meeting a checkpoint in the same cycle. It is paired with the case where the request meets the final progress step instead of a checkpoint. The bench times a suspend write from its own progress model so that the request is pending on the last step, and checks that the program completes rather than stalls. Other suspends land just before or on a checkpoint. The behavioural model decides on every clock in which cycle status bits 7 and 2 must rise, and the status port is compared against it.

// File: rtl/psr_pkg.sv
// Shared command codes, read-mode and command-class types for the
// program suspend/resume controller. Assumes byte-wide command codes.
package psr_pkg;
    localparam logic [7:0] OP_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_RD_STATUS = 8'h70;
    localparam logic [7:0] OP_RD_IDENT  = 8'h90;
    localparam logic [7:0] OP_RD_QUERY  = 8'h98;
    localparam logic [7:0] OP_PROGRAM   = 8'h40;
    localparam logic [7:0] OP_ERASE     = 8'h20;
    localparam logic [7:0] OP_CONFIRM   = 8'hD0;
    localparam logic [7:0] OP_SUSPEND   = 8'hB0;
    localparam logic [7:0] OP_CLEAR     = 8'h50;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_IDENT  = 2'd2,
        RM_QUERY  = 2'd3
    } rmode_t;

    typedef enum logic [3:0] {
        K_RD_ARRAY, K_RD_STATUS, K_RD_IDENT, K_RD_QUERY,
        K_PROGRAM, K_ERASE, K_CONFIRM, K_SUSPEND, K_CLEAR, K_OTHER
    } kind_t;

    typedef enum logic [1:0] {
        SU_NONE  = 2'd0,
        SU_PROG  = 2'd1,
        SU_ERASE = 2'd2
    } setup_t;
endpackage

// File: rtl/psr_cmd_class.sv
// Classifies a command byte into a command kind. Purely combinational;
// assumes the caller qualifies it with a valid write strobe.
module psr_cmd_class
    import psr_pkg::*;
(
    input  logic [7:0] code,
    output kind_t      kind
);
    // Map each recognised code to its kind, everything else to K_OTHER.
    always_comb begin
        case (code)
            OP_RD_ARRAY:  kind = K_RD_ARRAY;
            OP_RD_STATUS: kind = K_RD_STATUS;
            OP_RD_IDENT:  kind = K_RD_IDENT;
            OP_RD_QUERY:  kind = K_RD_QUERY;
            OP_PROGRAM:   kind = K_PROGRAM;
            OP_ERASE:     kind = K_ERASE;
            OP_CONFIRM:   kind = K_CONFIRM;
            OP_SUSPEND:   kind = K_SUSPEND;
            OP_CLEAR:     kind = K_CLEAR;
            default:      kind = K_OTHER;
        endcase
    end
endmodule

// File: rtl/psr_op_counter.sv
// Abstract progress of one embedded operation. Counts STEPS cycles while
// run is high and flags a checkpoint at the end of every CKPT-step
// interval except the final step. Assumes STEPS >= 2 and CKPT >= 2.
module psr_op_counter #(
    parameter int STEPS = 24,
    parameter int CKPT  = 4,
    parameter int CW    = $clog2(STEPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          run,
    output logic          active,
    output logic          ckpt,
    output logic [CW-1:0] progress
);
    localparam int PW = (CKPT > 1) ? $clog2(CKPT) : 1;
    localparam logic [CW-1:0] LAST  = CW'(STEPS - 1);
    localparam logic [PW-1:0] PHEND = PW'(CKPT - 1);

    logic [PW-1:0] phase;

    // Start, advance or finish the operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            progress <= '0;
            phase    <= '0;
        end else if (start) begin
            active   <= 1'b1;
            progress <= '0;
            phase    <= '0;
        end else if (active && run) begin
            if (progress == LAST) begin
                active <= 1'b0;
            end else begin
                progress <= progress + 1'b1;
                phase    <= (phase == PHEND) ? '0 : phase + 1'b1;
            end
        end
    end

    // A checkpoint is the end of a phase interval, never the last step.
    always_comb ckpt = active && (phase == PHEND) && (progress != LAST);
endmodule

// File: rtl/psr_ctrl.sv
// Command interface for a flash write engine with program suspend and
// nested program-in-erase-suspend. Assumes one command byte per write,
// writes qualified by wr_en with ce_n low, and synchronous active-low reset.
module psr_ctrl
    import psr_pkg::*;
#(
    parameter int BLK_W       = 7,
    parameter int PROG_STEPS  = 24,
    parameter int PROG_CKPT   = 4,
    parameter int ERASE_STEPS = 64,
    parameter int ERASE_CKPT  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             wr_en,
    input  logic [BLK_W-1:0] blk_addr,
    input  logic [7:0]       cmd_data,
    output logic [7:0]       status,
    output logic [1:0]       rd_mode
);
    localparam int P_CW = $clog2(PROG_STEPS);
    localparam int E_CW = $clog2(ERASE_STEPS);

    kind_t            kind;
    setup_t           setup_q;
    rmode_t           mode_q;
    logic             wr;
    logic             p_act, p_ckpt, p_sus, p_req, p_busy, p_run, p_start;
    logic             e_act, e_ckpt, e_sus, e_req, e_busy, e_run, e_start;
    logic             err_q;
    logic [BLK_W-1:0] e_blk;
    logic [P_CW-1:0]  p_progress;
    logic [E_CW-1:0]  e_progress;

    psr_cmd_class u_class (.code(cmd_data), .kind(kind));

    psr_op_counter #(.STEPS(PROG_STEPS), .CKPT(PROG_CKPT), .CW(P_CW)) u_prog (
        .clk(clk), .rst_n(rst_n), .start(p_start), .run(p_run),
        .active(p_act), .ckpt(p_ckpt), .progress(p_progress));

    psr_op_counter #(.STEPS(ERASE_STEPS), .CKPT(ERASE_CKPT), .CW(E_CW)) u_erase (
        .clk(clk), .rst_n(rst_n), .start(e_start), .run(e_run),
        .active(e_act), .ckpt(e_ckpt), .progress(e_progress));

    // Derive write strobe, busy flags, run enables and operation starts.
    always_comb begin
        wr      = wr_en && !ce_n;
        p_busy  = p_act && !p_sus;
        e_busy  = e_act && !e_sus;
        p_run   = p_busy && !(p_req && p_ckpt);
        e_run   = e_busy && !(e_req && e_ckpt);
        p_start = wr && (setup_q == SU_PROG);
        e_start = wr && (setup_q == SU_ERASE) && (cmd_data == OP_CONFIRM);
    end

    // Command decode, suspension bookkeeping and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q <= SU_NONE;
            mode_q  <= RM_ARRAY;
            p_sus   <= 1'b0;
            p_req   <= 1'b0;
            e_sus   <= 1'b0;
            e_req   <= 1'b0;
            err_q   <= 1'b0;
            e_blk   <= '0;
        end else begin
            if (p_req && p_ckpt) begin
                p_sus <= 1'b1;
                p_req <= 1'b0;
            end else if (!p_act) begin
                p_req <= 1'b0;
            end
            if (e_req && e_ckpt) begin
                e_sus <= 1'b1;
                e_req <= 1'b0;
            end else if (!e_act) begin
                e_req <= 1'b0;
            end
            if (wr) begin
                if (setup_q == SU_PROG) begin
                    setup_q <= SU_NONE;
                    mode_q  <= RM_STATUS;
                    p_req   <= 1'b0;
                end else if (setup_q == SU_ERASE) begin
                    setup_q <= SU_NONE;
                    if (cmd_data == OP_CONFIRM) begin
                        mode_q <= RM_STATUS;
                        e_blk  <= blk_addr;
                        e_req  <= 1'b0;
                    end else begin
                        err_q <= 1'b1;
                    end
                end else if (p_busy || e_busy) begin
                    if (kind == K_SUSPEND) begin
                        mode_q <= RM_STATUS;
                        if (p_busy) p_req <= 1'b1;
                        else        e_req <= 1'b1;
                    end else if (kind == K_RD_STATUS) begin
                        mode_q <= RM_STATUS;
                    end
                end else if (p_sus) begin
                    case (kind)
                        K_RD_ARRAY:  mode_q <= RM_ARRAY;
                        K_RD_STATUS: mode_q <= RM_STATUS;
                        K_RD_IDENT:  mode_q <= RM_IDENT;
                        K_RD_QUERY:  mode_q <= RM_QUERY;
                        K_CONFIRM: begin
                            p_sus  <= 1'b0;
                            p_req  <= 1'b0;
                            mode_q <= RM_STATUS;
                        end
                        default:     err_q <= 1'b1;
                    endcase
                end else if (e_sus) begin
                    case (kind)
                        K_RD_ARRAY:  mode_q <= RM_ARRAY;
                        K_RD_STATUS: mode_q <= RM_STATUS;
                        K_RD_IDENT:  mode_q <= RM_IDENT;
                        K_RD_QUERY:  mode_q <= RM_QUERY;
                        K_CLEAR:     err_q  <= 1'b0;
                        K_CONFIRM: begin
                            e_sus  <= 1'b0;
                            e_req  <= 1'b0;
                            mode_q <= RM_STATUS;
                        end
                        K_PROGRAM: begin
                            if (blk_addr == e_blk) err_q   <= 1'b1;
                            else                   setup_q <= SU_PROG;
                        end
                        default:     err_q <= 1'b1;
                    endcase
                end else begin
                    case (kind)
                        K_RD_ARRAY:  mode_q  <= RM_ARRAY;
                        K_RD_STATUS: mode_q  <= RM_STATUS;
                        K_RD_IDENT:  mode_q  <= RM_IDENT;
                        K_RD_QUERY:  mode_q  <= RM_QUERY;
                        K_PROGRAM:   setup_q <= SU_PROG;
                        K_ERASE:     setup_q <= SU_ERASE;
                        K_CLEAR:     err_q   <= 1'b0;
                        default:     ;
                    endcase
                end
            end
        end
    end

    // Assemble the status register and read-mode outputs.
    always_comb begin
        status  = {!(p_busy || e_busy), e_sus, 1'b0, err_q, 1'b0, p_sus, 2'b00};
        rd_mode = mode_q;
    end
endmodule

// File: rtl/psr_ctrl_checker.sv
// Temporal properties of the suspend/resume controller, bound into the top.
// Assumes it sees the top's internal suspension and progress signals.
module psr_ctrl_checker
    import psr_pkg::*;
#(
    parameter int PCW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ce_n,
    input logic           wr_en,
    input logic [7:0]     cmd_data,
    input logic [7:0]     status,
    input logic           p_sus,
    input logic           p_ckpt,
    input logic [PCW-1:0] p_progress,
    input setup_t         setup_q
);
    // R3: a program becomes suspended only from a checkpoint cycle.
    assert_susp_at_ckpt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_sus) |-> $past(p_ckpt));

    // R3: no progress is made across consecutive suspended cycles.
    assert_frozen_progress_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (p_sus && $past(p_sus)) |-> $stable(p_progress));

    // R6: resume while suspended clears suspension and readiness next cycle.
    assert_resume_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && wr_en && cmd_data == OP_CONFIRM && p_sus) |=> (!p_sus && !status[7]));

    // R10: standby keeps the suspended state.
    assert_standby_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && p_sus) |=> p_sus);

    // R7: suspend with nothing running leaves status at ready.
    assert_idle_suspend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && wr_en && cmd_data == OP_SUSPEND && status == 8'h80 && setup_q == SU_NONE)
        |=> status == 8'h80);
endmodule

bind psr_ctrl psr_ctrl_checker #(.PCW(P_CW)) u_checker (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_en(wr_en), .cmd_data(cmd_data),
    .status(status), .p_sus(p_sus), .p_ckpt(p_ckpt), .p_progress(p_progress),
    .setup_q(setup_q));

// File: tb/psr_ctrl_test.sv
module psr_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int BW  = 7;
    localparam int PS  = 24;
    localparam int PCK = 4;
    localparam int ES  = 64;
    localparam int ECK = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [BW-1:0] blk_addr = '0;
    logic [7:0]    cmd_data = 8'h00;
    logic [7:0]    status;
    logic [1:0]    rd_mode;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    psr_ctrl #(.BLK_W(BW), .PROG_STEPS(PS), .PROG_CKPT(PCK),
               .ERASE_STEPS(ES), .ERASE_CKPT(ECK)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_en(wr_en),
        .blk_addr(blk_addr), .cmd_data(cmd_data), .status(status), .rd_mode(rd_mode));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference state.
    int m_pa, m_pc, m_ps, m_pr, m_ea, m_ec, m_es, m_er, m_err, m_rm, m_setup, m_eblk;

    function automatic int read_code(input logic [7:0] c);
        case (c)
            8'hFF: return 0;
            8'h70: return 1;
            8'h90: return 2;
            8'h98: return 3;
            default: return -1;
        endcase
    endfunction

    task automatic model_step();
        int pb, eb, pck, eck, prun, erun, rc;
        int n_pa, n_pc, n_ps, n_pr, n_ea, n_ec, n_es, n_er, n_err, n_rm, n_setup, n_eblk;
        if (!rst_n) begin
            m_pa = 0; m_pc = 0; m_ps = 0; m_pr = 0; m_ea = 0; m_ec = 0; m_es = 0; m_er = 0;
            m_err = 0; m_rm = 0; m_setup = 0; m_eblk = 0;
            return;
        end
        pb = m_pa && !m_ps;  eb = m_ea && !m_es;
        pck = m_pa && (m_pc % PCK == PCK-1) && (m_pc != PS-1);
        eck = m_ea && (m_ec % ECK == ECK-1) && (m_ec != ES-1);
        prun = pb && !(m_pr && pck);
        erun = eb && !(m_er && eck);
        n_pa = m_pa; n_pc = m_pc; n_ps = m_ps; n_pr = m_pr; n_ea = m_ea; n_ec = m_ec;
        n_es = m_es; n_er = m_er; n_err = m_err; n_rm = m_rm; n_setup = m_setup; n_eblk = m_eblk;
        if (prun) begin if (m_pc == PS-1) n_pa = 0; else n_pc = m_pc + 1; end
        if (erun) begin if (m_ec == ES-1) n_ea = 0; else n_ec = m_ec + 1; end
        if (m_pr && pck) begin n_ps = 1; n_pr = 0; end else if (!m_pa) n_pr = 0;
        if (m_er && eck) begin n_es = 1; n_er = 0; end else if (!m_ea) n_er = 0;
        if (wr_en && !ce_n) begin
            rc = read_code(cmd_data);
            if (m_setup == 1) begin
                n_setup = 0; n_rm = 1; n_pr = 0; n_pa = 1; n_pc = 0;
            end else if (m_setup == 2) begin
                n_setup = 0;
                if (cmd_data == 8'hD0) begin
                    n_rm = 1; n_eblk = int'(blk_addr); n_er = 0; n_ea = 1; n_ec = 0;
                end else n_err = 1;
            end else if (pb || eb) begin
                if (cmd_data == 8'hB0) begin n_rm = 1; if (pb) n_pr = 1; else n_er = 1; end
                else if (cmd_data == 8'h70) n_rm = 1;
            end else if (m_ps) begin
                if (rc >= 0) n_rm = rc;
                else if (cmd_data == 8'hD0) begin n_ps = 0; n_pr = 0; n_rm = 1; end
                else n_err = 1;
            end else if (m_es) begin
                if (rc >= 0) n_rm = rc;
                else if (cmd_data == 8'h50) n_err = 0;
                else if (cmd_data == 8'hD0) begin n_es = 0; n_er = 0; n_rm = 1; end
                else if (cmd_data == 8'h40) begin
                    if (int'(blk_addr) == m_eblk) n_err = 1; else n_setup = 1;
                end else n_err = 1;
            end else begin
                if (rc >= 0) n_rm = rc;
                else if (cmd_data == 8'h40) n_setup = 1;
                else if (cmd_data == 8'h20) n_setup = 2;
                else if (cmd_data == 8'h50) n_err = 0;
            end
        end
        m_pa = n_pa; m_pc = n_pc; m_ps = n_ps; m_pr = n_pr; m_ea = n_ea; m_ec = n_ec;
        m_es = n_es; m_er = n_er; m_err = n_err; m_rm = n_rm; m_setup = n_setup; m_eblk = n_eblk;
    endtask

    always @(posedge clk) model_step();

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Per-clock comparison against the reference model.
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            chk("R2 ready", 32'(status[7]), 32'(!((m_pa && !m_ps) || (m_ea && !m_es))));
            chk("R3 prog-suspended", 32'(status[2]), 32'(m_ps));
            chk("R8 erase-suspended", 32'(status[6]), 32'(m_es));
            chk("R5 error", 32'(status[4]), 32'(m_err));
            chk("R4 read-mode", 32'(rd_mode), 32'(m_rm));
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(negedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr_cmd(input logic [7:0] c, input logic [BW-1:0] b);
        @(negedge clk); wr_en = 1'b1; cmd_data = c; blk_addr = b;
        @(negedge clk); wr_en = 1'b0; cmd_data = 8'h00;
    endtask

    task automatic wait_bit(input int bitn, input logic val, input string req);
        for (int i = 0; i < 400; i++) begin
            if (status[bitn] === val) return;
            @(negedge clk);
        end
        chk(req, 32'(status[bitn]), 32'(val));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", 32'(status), 32'h80);
        chk("R1 reset mode", 32'(rd_mode), 32'd0);

        // R7: suspend with nothing running.
        wr_cmd(8'hB0, 7'd9);
        chk("R7 idle suspend", 32'(status), 32'h80);

        // R2/R3: program, then suspend at an arbitrary block address.
        wr_cmd(8'h40, 7'd1);
        wr_cmd(8'h12, 7'd1);
        chk("R2 busy after start", 32'(status[7]), 32'd0);
        chk("R2 mode status", 32'(rd_mode), 32'd1);
        repeat (2) @(negedge clk);
        wr_cmd(8'hB0, 7'd77);
        wait_bit(2, 1'b1, "R3 suspend reached");
        chk("R3 suspended status", 32'(status), 32'h84);
        chk("R4 suspend selects status", 32'(rd_mode), 32'd1);

        // R4/R5: read modes and rejected commands while suspended.
        wr_cmd(8'h90, 7'd0);
        chk("R4 ident mode", 32'(rd_mode), 32'd2);
        wr_cmd(8'h98, 7'd0);
        chk("R4 query mode", 32'(rd_mode), 32'd3);
        wr_cmd(8'h40, 7'd0);
        chk("R5 program refused", 32'(status), 32'h94);
        wr_cmd(8'h50, 7'd0);
        chk("R5 clear refused", 32'(status), 32'h94);

        // R10: standby ignores writes and keeps the suspension.
        @(negedge clk); ce_n = 1'b1; wr_en = 1'b1; cmd_data = 8'hD0;
        repeat (4) @(negedge clk);
        wr_en = 1'b0; ce_n = 1'b0;
        chk("R10 standby holds", 32'(status), 32'h94);

        // R6: resume at any address, program then completes.
        wr_cmd(8'hFF, 7'd0);
        chk("R4 array mode", 32'(rd_mode), 32'd0);
        wr_cmd(8'hD0, 7'd55);
        chk("R6 resume clears", 32'(status & 8'h84), 32'h00);
        wait_bit(7, 1'b1, "R6 program finishes");
        wr_cmd(8'h50, 7'd0);
        chk("R11 clear error", 32'(status), 32'h80);

        // R13: non-suspend commands ignored while busy.
        wr_cmd(8'h40, 7'd2);
        wr_cmd(8'h00, 7'd2);
        wr_cmd(8'hFF, 7'd2);
        chk("R13 array ignored while busy", 32'(rd_mode), 32'd1);
        wr_cmd(8'h90, 7'd2);
        chk("R13 no error while busy", 32'(status), 32'h00);

        // R12: suspend pending on the last step is dropped.
        for (int i = 0; i < 100 && m_pc != 20; i++) @(negedge clk);
        wr_cmd(8'hB0, 7'd2);
        wait_bit(7, 1'b1, "R12 program completes");
        repeat (2) @(negedge clk);
        chk("R12 no late suspend", 32'(status), 32'h80);

        // R8: erase with a bad confirm byte.
        wr_cmd(8'h20, 7'd3);
        wr_cmd(8'h70, 7'd3);
        chk("R8 bad confirm", 32'(status), 32'h90);
        wr_cmd(8'h50, 7'd0);

        // R8/R9/R14: erase, suspend, nested program and suspend.
        wr_cmd(8'h20, 7'd3);
        wr_cmd(8'hD0, 7'd3);
        chk("R8 erase busy", 32'(status), 32'h00);
        wr_cmd(8'hB0, 7'd100);
        wait_bit(6, 1'b1, "R8 erase suspend reached");
        chk("R8 erase suspended", 32'(status), 32'hC0);
        wr_cmd(8'h40, 7'd3);
        chk("R14 same block refused", 32'(status), 32'hD0);
        wr_cmd(8'h50, 7'd0);
        chk("R11 clear in erase suspend", 32'(status), 32'hC0);
        wr_cmd(8'h40, 7'd7);
        wr_cmd(8'h3C, 7'd7);
        chk("R9 nested program runs", 32'(status), 32'h40);
        wr_cmd(8'hB0, 7'd0);
        wait_bit(2, 1'b1, "R9 nested suspend reached");
        chk("R9 nested suspended", 32'(status), 32'hC4);
        wr_cmd(8'hD0, 7'd0);
        chk("R9 program resumed first", 32'(status), 32'h40);
        wait_bit(7, 1'b1, "R9 nested program ends");
        chk("R9 back to erase suspend", 32'(status), 32'hC0);
        wr_cmd(8'hD0, 7'd0);
        chk("R9 erase resumed", 32'(status), 32'h00);
        wait_bit(7, 1'b1, "R8 erase ends");
        chk("R8 erase done", 32'(status), 32'h80);

        // R1: reset while suspended abandons the program.
        wr_cmd(8'h40, 7'd4);
        wr_cmd(8'h01, 7'd4);
        wr_cmd(8'hB0, 7'd4);
        wait_bit(2, 1'b1, "R3 suspend before reset");
        wr_cmd(8'h98, 7'd0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset in suspend status", 32'(status), 32'h80);
        chk("R1 reset in suspend mode", 32'(rd_mode), 32'd0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule